// File: doc/BRIEF.md
# Operand Bypass Selector and Load-Use Interlock

This block makes the hazard decisions for an in-order five-stage integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it takes the two source register indices of the instruction sitting in execute, compares them with the destination indices of the two older instructions in the memory and writeback stages, and produces a 2-bit select code for each ALU operand multiplexer. With these codes a result is taken from a pipeline register rather than from the register file. Because the register file writes in the first half of a cycle and reads in the second, the two older stages are the only ones that need comparing.

The block also checks the instruction in decode against a load currently in execute. If the decode instruction needs the value being loaded, the load data cannot arrive in time. The block then freezes the program counter and the fetch/decode register for one cycle and turns the decode/execute register load into a bubble, which acts as an instruction writing x0. Sources that an instruction does not read are masked out by per-source flags. A destination of x0 never counts as a producer. All outputs are combinational from the current inputs. The muxes, the pipeline registers and the register file sit outside the block.

Top module: `hu_hazard_ctrl`

## Requirements
- R1: An operand select is 00 (register file) when no older writing instruction in memory or writeback has a destination equal to that operand's source index.
- R2: An operand select is 01 when the memory-stage instruction writes (write flag 1), has a nonzero destination, and that destination equals the operand's source index.
- R3: An operand select is 10 when only the writeback-stage instruction writes a nonzero destination equal to the operand's source index.
- R4: When the memory-stage and writeback-stage destinations both match a source, the select is 01. The younger result wins.
- R5: A destination index of 0 never produces a nonzero select and never causes a stall.
- R6: A stage whose write flag is 0 never produces a forwarding select and never causes a stall.
- R7: A source whose used flag is 0 gives select 00 and causes no stall, whatever its index.
- R8: When execute holds a load (load flag 1, write flag 1, nonzero destination) whose destination equals a used decode source, the PC hold, fetch/decode hold and bubble outputs are all 1 in that same cycle.
- R9: A non-load instruction in execute never causes a stall, even when its destination matches a decode source.
- R10: The PC hold, fetch/decode hold and bubble outputs always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used to sample the embedded checks |
| rst_n | input | 1 | Active-low reset, disables the embedded checks |
| dec_rs1 | input | 5 | First source index of the decode-stage instruction |
| dec_rs1_used | input | 1 | Decode first source is read |
| dec_rs2 | input | 5 | Second source index of the decode-stage instruction |
| dec_rs2_used | input | 1 | Decode second source is read |
| ex_rs1 | input | 5 | First source index of the execute-stage instruction |
| ex_rs1_used | input | 1 | Execute first source is read |
| ex_rs2 | input | 5 | Second source index of the execute-stage instruction |
| ex_rs2_used | input | 1 | Execute second source is read |
| ex_rd | input | 5 | Destination index of the execute-stage instruction |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | 5 | Destination index of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | 5 | Destination index of the writeback-stage instruction |
| wb_wr | input | 1 | Writeback-stage instruction writes a register |
| fwd_sel_a | output | 2 | First ALU operand select: 00 register file, 01 memory stage, 10 writeback stage |
| fwd_sel_b | output | 2 | Second ALU operand select, same encoding |
| pc_hold | output | 1 | Keep the program counter unchanged this cycle |
| fd_hold | output | 1 | Keep the fetch/decode register unchanged this cycle |
| de_bubble | output | 1 | Load a bubble into the decode/execute register |

## Verification
The embedded checks assume the inputs come from one coherent pipeline snapshot that is stable around the sampling edge. They do not assume that a load never sits in memory with a dependent in execute: the block forwards from memory even then and leaves that case to the interlock upstream. The bench drives every input on the falling edge and reads the combinational outputs shortly after. It sweeps register indices 0 to 3, which covers x0, equal and unequal indices and every pairing of stages, together with all write, load and used flags. Each configuration therefore reaches both matching and non-matching comparisons.

// File: rtl/hu_pkg.sv
package hu_pkg;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    FWD_RF  = 2'b00,
    FWD_MEM = 2'b01,
    FWD_WB  = 2'b10
  } fwd_src_e;
endpackage

// File: rtl/hu_match.sv
// One producer/consumer comparison: a used source against a writing,
// nonzero destination.
module hu_match #(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] src,
  input  logic             src_used,
  input  logic [IDX_W-1:0] dst,
  input  logic             dst_wr,
  output logic             hit
);
  logic dst_live;

  always_comb begin
    dst_live = dst_wr && (dst != '0);
    hit      = src_used && dst_live && (dst == src);
  end
endmodule

// File: rtl/hu_fwd_pick.sv
// Bypass select for one ALU operand, memory stage ahead of writeback.
module hu_fwd_pick
  import hu_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] src,
  input  logic             src_used,
  input  logic [IDX_W-1:0] mem_rd,
  input  logic             mem_wr,
  input  logic [IDX_W-1:0] wb_rd,
  input  logic             wb_wr,
  output fwd_src_e         sel
);
  logic hit_mem;
  logic hit_wb;

  hu_match #(.IDX_W(IDX_W)) u_mem_cmp (
    .src(src), .src_used(src_used), .dst(mem_rd), .dst_wr(mem_wr), .hit(hit_mem)
  );

  hu_match #(.IDX_W(IDX_W)) u_wb_cmp (
    .src(src), .src_used(src_used), .dst(wb_rd), .dst_wr(wb_wr), .hit(hit_wb)
  );

  always_comb begin
    if (hit_mem)     sel = FWD_MEM;
    else if (hit_wb) sel = FWD_WB;
    else             sel = FWD_RF;
  end

  // R4: a match in both stages must take the younger value
  assert_younger_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_used && mem_wr && wb_wr && mem_rd == src && wb_rd == src && src != '0)
      |-> (sel == FWD_MEM));

  // R7: a source that is not read never selects a bypass
  assert_unused_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !src_used |-> (sel == FWD_RF));

  // R6: no writer in either stage means the register file value is used
  assert_no_writer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr && !wb_wr) |-> (sel == FWD_RF));
endmodule

// File: rtl/hu_load_use.sv
// Detects a load in execute whose result a decode source needs.
module hu_load_use #(
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0][IDX_W-1:0]   dec_src,
  input  logic [NUM_SRC-1:0]              dec_used,
  input  logic [IDX_W-1:0]                ex_rd,
  input  logic                            ex_wr,
  input  logic                            ex_is_load,
  output logic                            stall_req
);
  logic [NUM_SRC-1:0] src_hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    hu_match #(.IDX_W(IDX_W)) u_cmp (
      .src(dec_src[g]), .src_used(dec_used[g]),
      .dst(ex_rd), .dst_wr(ex_wr), .hit(src_hit[g])
    );
  end

  always_comb begin
    stall_req = ex_is_load && (|src_hit);
  end

  // R9: only a load can interlock
  assert_nonload_no_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_is_load |-> !stall_req);

  // R5: a load to x0 is no producer
  assert_x0_no_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd == '0) |-> !stall_req);
endmodule

// File: rtl/hu_hazard_ctrl.sv
module hu_hazard_ctrl
  import hu_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] dec_rs1,
  input  logic             dec_rs1_used,
  input  logic [IDX_W-1:0] dec_rs2,
  input  logic             dec_rs2_used,
  input  logic [IDX_W-1:0] ex_rs1,
  input  logic             ex_rs1_used,
  input  logic [IDX_W-1:0] ex_rs2,
  input  logic             ex_rs2_used,
  input  logic [IDX_W-1:0] ex_rd,
  input  logic             ex_wr,
  input  logic             ex_is_load,
  input  logic [IDX_W-1:0] mem_rd,
  input  logic             mem_wr,
  input  logic [IDX_W-1:0] wb_rd,
  input  logic             wb_wr,
  output logic [1:0]       fwd_sel_a,
  output logic [1:0]       fwd_sel_b,
  output logic             pc_hold,
  output logic             fd_hold,
  output logic             de_bubble
);
  localparam int unsigned NUM_SRC = 2;

  logic [NUM_SRC-1:0][IDX_W-1:0] ex_src;
  logic [NUM_SRC-1:0]            ex_used;
  logic [NUM_SRC-1:0][IDX_W-1:0] dec_src;
  logic [NUM_SRC-1:0]            dec_used;
  fwd_src_e                      sel [NUM_SRC];
  logic                          stall_req;

  always_comb begin
    ex_src   = {ex_rs2, ex_rs1};
    ex_used  = {ex_rs2_used, ex_rs1_used};
    dec_src  = {dec_rs2, dec_rs1};
    dec_used = {dec_rs2_used, dec_rs1_used};
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
    hu_fwd_pick #(.IDX_W(IDX_W)) u_pick (
      .clk(clk), .rst_n(rst_n),
      .src(ex_src[g]), .src_used(ex_used[g]),
      .mem_rd(mem_rd), .mem_wr(mem_wr),
      .wb_rd(wb_rd), .wb_wr(wb_wr),
      .sel(sel[g])
    );
  end

  hu_load_use #(.IDX_W(IDX_W), .NUM_SRC(NUM_SRC)) u_interlock (
    .clk(clk), .rst_n(rst_n),
    .dec_src(dec_src), .dec_used(dec_used),
    .ex_rd(ex_rd), .ex_wr(ex_wr), .ex_is_load(ex_is_load),
    .stall_req(stall_req)
  );

  always_comb begin
    fwd_sel_a = sel[0];
    fwd_sel_b = sel[1];
    pc_hold   = stall_req;
    fd_hold   = stall_req;
    de_bubble = stall_req;
  end

  // R10: the three interlock controls move together
  assert_stall_coherent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_hold == fd_hold) && (fd_hold == de_bubble));

  // R5: x0 in both older stages never yields a bypass
  assert_x0_no_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd == '0 && wb_rd == '0) |-> (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00));

  // R1: the code 11 is never produced
  assert_sel_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_sel_a != 2'b11) && (fwd_sel_b != 2'b11));
endmodule

// File: tb/hu_hazard_ctrl_tb_top.sv
module hu_hazard_ctrl_tb_top;
  logic       clk;
  logic       rst_n;
  logic [4:0] dec_rs1, dec_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic       dec_rs1_used, dec_rs2_used, ex_rs1_used, ex_rs2_used;
  logic       ex_wr, ex_is_load, mem_wr, wb_wr;
  logic [1:0] fwd_sel_a, fwd_sel_b;
  logic       pc_hold, fd_hold, de_bubble;

  int n_run  = 0;
  int n_fail = 0;

  hu_hazard_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .dec_rs1(dec_rs1), .dec_rs1_used(dec_rs1_used),
    .dec_rs2(dec_rs2), .dec_rs2_used(dec_rs2_used),
    .ex_rs1(ex_rs1), .ex_rs1_used(ex_rs1_used),
    .ex_rs2(ex_rs2), .ex_rs2_used(ex_rs2_used),
    .ex_rd(ex_rd), .ex_wr(ex_wr), .ex_is_load(ex_is_load),
    .mem_rd(mem_rd), .mem_wr(mem_wr),
    .wb_rd(wb_rd), .wb_wr(wb_wr),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
    .pc_hold(pc_hold), .fd_hold(fd_hold), .de_bubble(de_bubble)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [1:0] exp_sel(input logic [4:0] s, input logic u,
      input logic [4:0] mr, input logic mw, input logic [4:0] wr, input logic ww);
    if (u && mw && mr != 0 && mr == s)      return 2'b01;
    else if (u && ww && wr != 0 && wr == s) return 2'b10;
    else                                    return 2'b00;
  endfunction

  function automatic string sel_tag(input logic [4:0] s, input logic u,
      input logic [4:0] mr, input logic mw, input logic [4:0] wr, input logic ww);
    logic mm, wm;
    mm = (mr == s);
    wm = (wr == s);
    if (!u)                             return "R7";
    if ((mm || wm) && s == 0)           return "R5";
    if ((mm && !mw) || (wm && !ww))     return "R6";
    if (mm && wm)                       return "R4";
    if (mm)                             return "R2";
    if (wm)                             return "R3";
    return "R1";
  endfunction

  task automatic check2(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    {dec_rs1, dec_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd} = '0;
    {dec_rs1_used, dec_rs2_used, ex_rs1_used, ex_rs2_used} = '0;
    {ex_wr, ex_is_load, mem_wr, wb_wr} = '0;
  endtask

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    // R1 reset state: no producer, selects 00, no stall (R10)
    check2("R1", fwd_sel_a, 2'b00);
    check2("R1", fwd_sel_b, 2'b00);
    check2("R10", {pc_hold, fd_hold, de_bubble}, {3{1'b0}});
    rst_n = 1'b1;

    // Forwarding sweep: indices 0..3 over all flags
    for (int s1 = 0; s1 < 4; s1++)
      for (int s2 = 0; s2 < 4; s2++)
        for (int mr = 0; mr < 4; mr++)
          for (int wr = 0; wr < 4; wr++)
            for (int fl = 0; fl < 16; fl++) begin
              @(negedge clk);
              ex_rs1 = 5'(s1); ex_rs2 = 5'(s2);
              mem_rd = 5'(mr); wb_rd = 5'(wr);
              mem_wr = fl[0]; wb_wr = fl[1];
              ex_rs1_used = fl[2]; ex_rs2_used = fl[3];
              #1;
              check2(sel_tag(ex_rs1, ex_rs1_used, mem_rd, mem_wr, wb_rd, wb_wr), fwd_sel_a,
                     exp_sel(ex_rs1, ex_rs1_used, mem_rd, mem_wr, wb_rd, wb_wr));
              check2(sel_tag(ex_rs2, ex_rs2_used, mem_rd, mem_wr, wb_rd, wb_wr), fwd_sel_b,
                     exp_sel(ex_rs2, ex_rs2_used, mem_rd, mem_wr, wb_rd, wb_wr));
            end

    // Interlock sweep
    idle_inputs();
    for (int d1 = 0; d1 < 4; d1++)
      for (int d2 = 0; d2 < 4; d2++)
        for (int rd = 0; rd < 4; rd++)
          for (int fl = 0; fl < 16; fl++) begin
            logic hit1, hit2, exp_st;
            string tg;
            @(negedge clk);
            dec_rs1 = 5'(d1); dec_rs2 = 5'(d2); ex_rd = 5'(rd);
            ex_wr = fl[0]; ex_is_load = fl[1];
            dec_rs1_used = fl[2]; dec_rs2_used = fl[3];
            #1;
            hit1 = dec_rs1_used && dec_rs1 == ex_rd;
            hit2 = dec_rs2_used && dec_rs2 == ex_rd;
            exp_st = ex_is_load && ex_wr && ex_rd != 0 && (hit1 || hit2);
            if (ex_rd == 0 && (hit1 || hit2))           tg = "R5";
            else if (!ex_wr && (hit1 || hit2))          tg = "R6";
            else if (!ex_is_load && (hit1 || hit2))     tg = "R9";
            else if (!(hit1 || hit2) && ex_is_load &&
                     (dec_rs1 == ex_rd || dec_rs2 == ex_rd)) tg = "R7";
            else                                        tg = "R8";
            check2(tg, {1'b0, pc_hold}, {1'b0, exp_st});
            // R10: all three interlock outputs equal the same expectation
            check2("R10", {fd_hold, de_bubble}, {2{exp_st}});
          end

    // Directed: load-use on second source only, R8
    idle_inputs();
    @(negedge clk);
    ex_rd = 5'd7; ex_wr = 1'b1; ex_is_load = 1'b1;
    dec_rs2 = 5'd7; dec_rs2_used = 1'b1; dec_rs1 = 5'd3; dec_rs1_used = 1'b1;
    #1;
    check2("R8", {pc_hold, de_bubble}, 2'b11);
    // Directed: same index with the source marked unused, R7
    @(negedge clk);
    dec_rs2_used = 1'b0;
    #1;
    check2("R7", {pc_hold, de_bubble}, 2'b00);
    // Directed: high index forwarded from both stages, R4
    @(negedge clk);
    ex_rs1 = 5'd31; ex_rs1_used = 1'b1; mem_rd = 5'd31; mem_wr = 1'b1;
    wb_rd = 5'd31; wb_wr = 1'b1;
    #1;
    check2("R4", fwd_sel_a, 2'b01);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule